// File: doc/BRIEF.md
# Write-Status Polling Responder

This unit sits next to the read path of a memory array model and takes over the read data while an internal program or erase runs. A start pulse tells it which operation began and, for a program, which word is being written. From then on, every read returns status instead of array contents. Bit 7 acts as a completion flag. Bit 6 flips on each read for as long as the operation is busy. The other bits read as zero.

Each operation kind has its own busy length, set by a parameter and counted by an internal timer. When the timer expires, bit 7 shows its true value at once. The full word stays unreliable for a parameterized settling window. After that window, reads pass the array data through unchanged. The host can poll in either of two ways: compare bit 7 against the expected value, or read twice and watch whether bit 6 still changes.

Top module: `wsp_status_responder`

## Requirements
- R1: After reset, with no operation started, `rd_data` equals `array_rdata`. A reset during an operation also returns the unit to pass-through.
- R2: While a program is busy (`op_kind` = 0), bit 7 of `rd_data` is the complement of bit 7 of the `prog_word` captured with the start pulse.
- R3: While any erase is busy (`op_kind` 1 = sector, 2 = block, 3 = chip), bit 7 of `rd_data` is 0.
- R4: Bit 6 of `rd_data` reads 0 on the first cycle after a start. Each cycle with `rd_strobe` high while busy inverts bit 6 for the next cycle.
- R5: While busy and during the settling window, bits 15..8 and 5..0 of `rd_data` are 0.
- R6: A start accepted on one clock edge keeps the unit busy for exactly PROG_CYC, SECT_CYC, BLOCK_CYC or CHIP_CYC cycles, chosen by `op_kind`.
- R7: For SETTLE_CYC cycles after busy ends, bit 7 shows its true value (the captured bit 7 for a program, 1 for an erase) while the other bits follow R5.
- R8: A start pulse during a busy period is ignored. Kind, captured word, duration and bit 6 state are all unchanged.
- R9: After busy ends, bit 6 no longer changes, whether or not reads occur.
- R10: After the settling window, `rd_data` equals `array_rdata` whatever `rd_strobe` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse: an internal operation begins |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| prog_word | input | 16 | Word being programmed; sampled with `op_start` |
| rd_strobe | input | 1 | One read access this cycle |
| array_rdata | input | 16 | Data from the array read path |
| rd_data | output | 16 | Data returned to the host |

## Verification
A wrong busy counter moves the cycle where bit 7 switches to its true value, so a single cycle-accurate compare catches it. A toggle flop that misses or double-counts reads shows on bit 6 at the first read after the error. A wrong operation latch inverts bit 7 from the first cycle after the start. A broken settling window shows as array data appearing too early or too late, at the exact cycle boundary. The sweep compares every cycle of every operation kind, under dense, sparse and absent read patterns, so any of these faults is reported within one cycle of its effect.

// File: rtl/wsp_pkg.sv
// Shared types for the write-status polling responder.
package wsp_pkg;
    // Operation kinds; the encoding matches the op_kind input.
    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_CHIP  = 2'd3
    } op_kind_e;
endpackage

// File: rtl/wsp_busy_timer.sv
// Busy timer: on launch, loads the duration of the given operation kind and
// holds busy high for exactly that many cycles. done marks the final busy cycle.
// Assumes launch is only raised while not busy, and every duration is >= 1.
module wsp_busy_timer
    import wsp_pkg::*;
#(
    parameter int PROG_CYC  = 6,
    parameter int SECT_CYC  = 10,
    parameter int BLOCK_CYC = 12,
    parameter int CHIP_CYC  = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     launch,
    input  op_kind_e kind,
    output logic     busy,
    output logic     done
);
    localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_B   = (BLOCK_CYC > CHIP_CYC) ? BLOCK_CYC : CHIP_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [CNT_W-1:0] remain;

    // Cycles left minus one, for the chosen operation kind.
    function automatic logic [CNT_W-1:0] load_of(op_kind_e k);
        case (k)
            OP_PROG:  return CNT_W'(PROG_CYC - 1);
            OP_SECT:  return CNT_W'(SECT_CYC - 1);
            OP_BLOCK: return CNT_W'(BLOCK_CYC - 1);
            default:  return CNT_W'(CHIP_CYC - 1);
        endcase
    endfunction

    // Load on launch, count down while busy, drop busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (launch) begin
            busy   <= 1'b1;
            remain <= load_of(kind);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    // Final cycle of the busy period.
    always_comb done = busy && (remain == '0);

    // R6 / R8: a busy period runs its count down one step per cycle, undisturbed.
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain != '0) |=> (busy && remain == $past(remain) - 1'b1));

    // R6: busy ends on the cycle after done.
    p_busy_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/wsp_toggle_bit.sv
// Toggle-bit state: cleared when an operation launches, and inverted by each
// read strobe while busy. Frozen at all other times.
// Assumes launch never coincides with busy.
module wsp_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic busy,
    input  logic rd_strobe,
    output logic tog
);
    // Clear at launch, flip per read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tog <= 1'b0;
        else if (launch)            tog <= 1'b0;
        else if (busy && rd_strobe) tog <= ~tog;
    end

    // R4: every busy read inverts the flag seen by the next read.
    p_flip_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe) |=> (tog != $past(tog)));

    // R9: once idle, the flag holds until the next launch.
    p_frozen_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !launch) |=> $stable(tog));
endmodule

// File: rtl/wsp_settle_window.sv
// Settling window: opens when the busy timer signals done and stays open for
// SETTLE_CYC cycles. A new launch closes it early. SETTLE_CYC = 0 removes it.
// Assumes done and launch never coincide.
module wsp_settle_window #(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic launch,
    output logic active
);
    generate
        if (SETTLE_CYC == 0) begin : g_none
            assign active = 1'b0;
        end else begin : g_win
            localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
            logic [SW-1:0] left;
            logic          open_q;

            // Open on done, count the window down, close on launch.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    open_q <= 1'b0;
                    left   <= '0;
                end else if (launch) begin
                    open_q <= 1'b0;
                end else if (done) begin
                    open_q <= 1'b1;
                    left   <= SW'(SETTLE_CYC - 1);
                end else if (open_q) begin
                    if (left == '0) open_q <= 1'b0;
                    else            left   <= left - 1'b1;
                end
            end

            assign active = open_q;

            // R7: the window follows the end of every busy period.
            p_window_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
                done |=> open_q);

            // R7: a new operation closes any open window.
            p_window_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
                launch |=> !open_q);
        end
    endgenerate
endmodule

// File: rtl/wsp_status_responder.sv
// Write-status polling responder. It overrides read data with a completion
// flag (bit 7) and a toggle flag (bit 6) while an internal program or erase
// is busy, then through a settling window. After that it passes array data.
// Assumes op_start is a one-cycle pulse. Starts that arrive while busy are dropped.
module wsp_status_responder
    import wsp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int PROG_CYC   = 6,
    parameter int SECT_CYC   = 10,
    parameter int BLOCK_CYC  = 12,
    parameter int CHIP_CYC   = 16,
    parameter int SETTLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [DATA_W-1:0] prog_word,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;

    logic busy, done, settling, tog, launch;
    logic is_prog, word_b7;

    // Accept a start only when no operation is running.
    always_comb launch = op_start && !busy;

    wsp_busy_timer #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .BLOCK_CYC(BLOCK_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .launch(launch),
        .kind  (op_kind_e'(op_kind)),
        .busy  (busy),
        .done  (done)
    );

    wsp_toggle_bit u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .busy     (busy),
        .rd_strobe(rd_strobe),
        .tog      (tog)
    );

    wsp_settle_window #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done),
        .launch(launch),
        .active(settling)
    );

    // Capture the operation class and the programmed bit 7 at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_prog <= 1'b0;
            word_b7 <= 1'b0;
        end else if (launch) begin
            is_prog <= (op_kind_e'(op_kind) == OP_PROG);
            word_b7 <= prog_word[POLL_BIT];
        end
    end

    // Select status or array data for the host.
    always_comb begin
        logic true_b7;
        true_b7 = is_prog ? word_b7 : 1'b1;
        if (busy || settling) begin
            rd_data           = '0;
            rd_data[POLL_BIT] = busy ? (is_prog ? ~word_b7 : 1'b0) : true_b7;
            rd_data[TOG_BIT]  = tog;
        end else begin
            rd_data = array_rdata;
        end
    end

    // R2: the first read after a program start shows the inverted bit 7.
    p_prog_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && op_kind == 2'd0) |=> (rd_data[POLL_BIT] == ~$past(prog_word[POLL_BIT])));

    // R3: the first read after an erase start shows 0 on bit 7.
    p_erase_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && op_kind != 2'd0) |=> (rd_data[POLL_BIT] == 1'b0));

    // R4: bit 6 starts at 0 for every new operation.
    p_tog_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (rd_data[TOG_BIT] == 1'b0));

    // R5: non-flag bits are quiet during status reporting.
    p_quiet_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || settling) |-> ((rd_data & ~(DATA_W'(1) << POLL_BIT) & ~(DATA_W'(1) << TOG_BIT)) == '0));
endmodule

// File: tb/tb_wsp_status_responder.sv
// Sweep bench: every operation kind, both values of the programmed bit 7, and
// three read patterns, with a per-cycle compare against an arithmetic model.
module tb_wsp_status_responder;
    localparam int P_CYC = 6, S_CYC = 10, B_CYC = 12, C_CYC = 16, SET_CYC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [15:0] prog_word = '0;
    logic        rd_strobe = 1'b0;
    logic [15:0] array_rdata = 16'h0000;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wsp_status_responder #(
        .DATA_W(16), .PROG_CYC(P_CYC), .SECT_CYC(S_CYC),
        .BLOCK_CYC(B_CYC), .CHIP_CYC(C_CYC), .SETTLE_CYC(SET_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .prog_word(prog_word), .rd_strobe(rd_strobe),
        .array_rdata(array_rdata), .rd_data(rd_data)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int dur_of(input int k);
        case (k)
            0: return P_CYC;
            1: return S_CYC;
            2: return B_CYC;
            default: return C_CYC;
        endcase
    endfunction

    // One operation: start, then compare every cycle through busy, settle and idle.
    task automatic run_op(input int kind, input bit b7, input int pat, input bit inject);
        int  dur;
        bit  etog;
        bit  strobe;
        logic [15:0] exp;
        dur  = dur_of(kind);
        etog = 1'b0;
        @(negedge clk);
        op_start    = 1'b1;
        op_kind     = 2'(kind);
        prog_word   = {8'h5A, b7, 7'h33};
        array_rdata = 16'h3C00 ^ 16'(kind * 16'h0111) ^ 16'(pat) ^ {8'h00, b7, 7'h00};
        rd_strobe   = 1'b0;
        for (int k = 1; k <= dur + SET_CYC + 3; k++) begin
            @(negedge clk);
            op_start = inject && (k == 3);
            if (inject) begin
                op_kind   = 2'(3 - kind);
                prog_word = ~prog_word;
            end
            strobe = (pat == 0) ? 1'b1 : (pat == 1) ? bit'(k % 2) : 1'b0;
            rd_strobe = strobe;
            #1;
            if (k <= dur) begin
                exp = {8'h00, (kind == 0) ? ~b7 : 1'b0, etog, 6'h00};
                if (kind == 0) check(rd_data, exp, inject ? "R2 R4 R5 R6 R8" : "R2 R4 R5 R6");
                else           check(rd_data, exp, inject ? "R3 R4 R5 R6 R8" : "R3 R4 R5 R6");
                if (strobe) etog = ~etog;
            end else if (k <= dur + SET_CYC) begin
                exp = {8'h00, (kind == 0) ? b7 : 1'b1, etog, 6'h00};
                check(rd_data, exp, "R7 R9 R5");
            end else begin
                check(rd_data, array_rdata, "R10");
            end
        end
        @(negedge clk);
        op_start  = 1'b0;
        rd_strobe = 1'b0;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        array_rdata = 16'hBEEF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(rd_data, 16'hBEEF, "R1 reset state");

        for (int kind = 0; kind < 4; kind++)
            for (int b = 0; b < 2; b++)
                for (int pat = 0; pat < 3; pat++)
                    run_op(kind, bit'(b), pat, 1'b0);

        // R8: starts injected mid-busy must not disturb the running operation.
        run_op(0, 1'b1, 0, 1'b1);
        run_op(1, 1'b0, 1, 1'b1);
        run_op(3, 1'b1, 0, 1'b1);

        // R1: reset in the middle of an erase returns to pass-through.
        @(negedge clk);
        op_start = 1'b1; op_kind = 2'd3; array_rdata = 16'h1234;
        @(negedge clk);
        op_start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rd_data, 16'h1234, "R1 reset mid-operation");
        @(negedge clk);
        #1;
        check(rd_data, 16'h1234, "R1 stays idle after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule